// File: doc/BRIEF.md
# I2C Master Serial Clock Rate Generator

This block produces the serial clock for an I2C controller operating as bus master. It runs on the peripheral clock and drives the SCL line through an open-drain style pull-low request. A 7-bit rate setting fixes the half-period at the setting plus three clock cycles, so one full SCL bit lasts twice that. The block also emits one-clock strobes on the SCL falling and rising edges, which the byte shifter uses to time data changes and sampling.

The high phase is counted only once the line is sensed high. A slave that stretches the clock by holding SCL low therefore lengthens the bit instead of shortening the high time. In slave mode the generator stays idle and leaves SCL to the external master.

While the processor sits in debug state and the keep-running bit is clear, the generator freezes. The pull-low request and the phase counter keep their values, and operation carries on from that point once debug state ends.

Top module: `i2c_scl_rategen`

## Requirements
- R1: With no stretching, `scl_pull_low` stays high for exactly `rate_sel`+3 cycles and then low for exactly `rate_sel`+3 cycles, giving a bit period of 2×(`rate_sel`+3) clocks.
- R2: A `rate_sel` of 0 behaves as 1, so the half-period is never below 4 cycles.
- R3: With `master_mode` at 0 the block keeps `scl_pull_low`, `scl_rise` and `scl_fall` at 0, whatever `enable` is.
- R4: With `enable` at 0 the block releases SCL and clears its counter. If `enable` is sampled high at a clock edge while the block is idle, `scl_pull_low` and `scl_fall` are both 1 in the cycle that follows that edge.
- R5: After the pull-low request is released, the high phase is counted from the first clock edge at which `scl_sense` is 1. A line held low by a slave for S extra edges lengthens the released time to `rate_sel`+3+S cycles.
- R6: While `dbg_halt` is 1 and `dbg_keep_run` is 0, `scl_pull_low` and the phase counter hold their values, and `scl_rise` and `scl_fall` stay 0.
- R7: When the freeze ends, the current phase completes its remaining cycles. The phase length equals `rate_sel`+3 plus the number of frozen clock edges.
- R8: While `dbg_keep_run` is 1, `dbg_halt` has no effect on the timing.
- R9: `scl_fall` is a one-cycle pulse in the first cycle of each low phase. `scl_rise` is a one-cycle pulse in the cycle after the first edge at which SCL is sensed high. Without stretching, that is the second released cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 7 | Half-period setting; the half-period is this value plus 3 cycles |
| master_mode | input | 1 | 1 selects master operation; 0 keeps the generator idle |
| enable | input | 1 | Runs the generator when high |
| dbg_halt | input | 1 | Processor is in debug state |
| dbg_keep_run | input | 1 | 1 keeps the generator running during debug state |
| scl_sense | input | 1 | Sensed SCL line level, already synchronized |
| scl_pull_low | output | 1 | Request to pull SCL low (open-drain drive) |
| scl_rise | output | 1 | One-cycle strobe following the sensed SCL rise |
| scl_fall | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The bench measures low and high phase lengths for several rate settings, including 0 and 127. An off-by-one in the terminal count or a missing clamp would show up there as a wrong half-period. It holds the line low past the release to confirm that the high phase starts only when the line is sensed high; a generator that counted from the release would cut the high time short. A freeze in the middle of a low phase must stretch that phase by exactly the frozen edge count. A design that reset or kept counting during the freeze would give a shorter phase, and one that let strobes through would be caught as well. Slave mode, the enable latency and dropping `enable` in mid-phase are checked directly at the outputs.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_CLEAR = 2'd1,
        CTR_SET1  = 2'd2,
        CTR_INC   = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic active;
        logic advance;
    } run_ctl_s;

    function automatic int unsigned half_len(int unsigned rate, int unsigned offs);
        return ((rate == 0) ? 1 : rate) + offs;
    endfunction

endpackage

// File: rtl/scl_run_gate.sv
module scl_run_gate
    import scl_gen_pkg::*;
(
    input  logic     master_mode,
    input  logic     enable,
    input  logic     dbg_halt,
    input  logic     dbg_keep_run,
    output run_ctl_s ctl
);
    always_comb begin
        ctl.active  = master_mode & enable;
        ctl.advance = ~(dbg_halt & ~dbg_keep_run);
    end
endmodule

// File: rtl/scl_half_ctr.sv
module scl_half_ctr
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_op_e          op,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            unique case (op)
                CTR_HOLD:  cnt <= cnt;
                CTR_CLEAR: cnt <= '0;
                CTR_SET1:  cnt <= CNT_W'(1);
                CTR_INC:   cnt <= cnt + CNT_W'(1);
                default:   cnt <= cnt;
            endcase
        end
    end

    // The >= compare keeps a shrunken rate from letting the count run past the end.
    assign at_end = (cnt >= last_val);

    // R6: a hold request from the sequencer leaves the count untouched
    p_ctr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(op == CTR_HOLD) |-> $stable(cnt));
endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen
    import scl_gen_pkg::*;
#(
    parameter int RATE_W = 7,
    parameter int OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              master_mode,
    input  logic              enable,
    input  logic              dbg_halt,
    input  logic              dbg_keep_run,
    input  logic              scl_sense,
    output logic              scl_pull_low,
    output logic              scl_rise,
    output logic              scl_fall
);
    localparam int MAX_HALF = (1 << RATE_W) - 1 + OFFSET;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    run_ctl_s         ctl;
    scl_phase_e       phase_q, phase_d;
    ctr_op_e          op;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;
    logic             at_end;
    logic             rise_d, fall_d;
    logic             rise_q, fall_q;
    logic             past_ok;

    scl_run_gate u_gate (
        .master_mode (master_mode),
        .enable      (enable),
        .dbg_halt    (dbg_halt),
        .dbg_keep_run(dbg_keep_run),
        .ctl         (ctl)
    );

    assign last_val = CNT_W'(half_len(32'(rate_sel), OFFSET) - 1);

    scl_half_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .last_val(last_val),
        .cnt     (cnt),
        .at_end  (at_end)
    );

    always_comb begin
        phase_d = phase_q;
        op      = CTR_HOLD;
        rise_d  = 1'b0;
        fall_d  = 1'b0;
        if (!ctl.advance) begin
            phase_d = phase_q;
        end else if (!ctl.active) begin
            phase_d = PH_IDLE;
            op      = CTR_CLEAR;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_LOW;
                    op      = CTR_CLEAR;
                    fall_d  = 1'b1;
                end
                PH_LOW: begin
                    if (at_end) begin
                        phase_d = PH_WAIT;
                        op      = CTR_CLEAR;
                    end else begin
                        op      = CTR_INC;
                    end
                end
                PH_WAIT: begin
                    if (scl_sense) begin
                        phase_d = PH_HIGH;
                        op      = CTR_SET1;
                        rise_d  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (at_end) begin
                        phase_d = PH_LOW;
                        op      = CTR_CLEAR;
                        fall_d  = 1'b1;
                    end else begin
                        op      = CTR_INC;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            phase_q <= phase_d;
            rise_q  <= rise_d;
            fall_q  <= fall_d;
        end
    end

    assign scl_pull_low = (phase_q == PH_LOW);
    assign scl_rise     = rise_q;
    assign scl_fall     = fall_q;

    // R9: the fall strobe marks a cycle in which the line is being pulled low
    p_fall_in_low_r9: assert property (@(posedge clk) disable iff (rst)
        scl_fall |-> scl_pull_low);

    // R9: the rise strobe follows an edge at which the line was sensed high
    p_rise_sensed_r9: assert property (@(posedge clk) disable iff (rst)
        past_ok && scl_rise |-> $past(scl_sense) && !scl_pull_low);

    // R6: a frozen edge leaves the drive unchanged and raises no strobe
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(dbg_halt && !dbg_keep_run) |->
            $stable(scl_pull_low) && !scl_rise && !scl_fall);

    // R3: slave mode leaves the line released and silent
    p_slave_idle_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(!master_mode && !(dbg_halt && !dbg_keep_run)) |->
            !scl_pull_low && !scl_rise && !scl_fall);

    // R4: a disabled, running generator releases the line
    p_disable_release_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(!enable && !(dbg_halt && !dbg_keep_run)) |-> !scl_pull_low);
endmodule

// File: tb/i2c_scl_rategen_test.sv
`timescale 1ns/1ps
module i2c_scl_rategen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] rate_sel = 7'd1;
    logic       master_mode = 1'b1;
    logic       enable = 1'b0;
    logic       dbg_halt = 1'b0;
    logic       dbg_keep_run = 1'b0;
    logic       slave_hold = 1'b0;
    logic       scl_sense;
    logic       scl_pull_low, scl_rise, scl_fall;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    // open-drain line: low if the generator or a stretching slave pulls it
    assign scl_sense = ~(scl_pull_low | slave_hold);

    i2c_scl_rategen uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .master_mode(master_mode),
        .enable(enable), .dbg_halt(dbg_halt), .dbg_keep_run(dbg_keep_run),
        .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    // {rate setting, expected half-period}
    localparam logic [15:0] VEC [5] = '{
        {8'd1,   8'd4},
        {8'd0,   8'd4},
        {8'd10,  8'd13},
        {8'd50,  8'd53},
        {8'd127, 8'd130}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [6:0] r);
        enable   = 1'b0;
        rate_sel = r;
        repeat (3) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic wait_fall();
        int n = 0;
        while (!scl_fall && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_low(output int lowc);
        lowc = 0;
        while (scl_pull_low && lowc < 2000) begin
            lowc++;
            @(negedge clk);
        end
    endtask

    task automatic run_high(output int highc, output int rises, output int rise_at);
        highc = 0; rises = 0; rise_at = 0;
        while (!scl_pull_low && highc < 2000) begin
            highc++;
            if (scl_rise) begin
                rises++;
                if (rise_at == 0) rise_at = highc;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lowc, highc, rises, rise_at, bad;
        // reset state
        repeat (3) @(negedge clk);
        chk(!scl_pull_low && !scl_rise && !scl_fall, "R4 reset released",
            int'({scl_pull_low, scl_rise, scl_fall}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R9: phase lengths over the table
        for (int i = 0; i < 5; i++) begin
            restart(VEC[i][14:8]);
            wait_fall();
            run_low(lowc);
            chk(lowc == int'(VEC[i][7:0]), $sformatf("R1/R2 low rate=%0d", VEC[i][14:8]),
                lowc, int'(VEC[i][7:0]));
            run_high(highc, rises, rise_at);
            chk(highc == int'(VEC[i][7:0]), $sformatf("R1/R2 high rate=%0d", VEC[i][14:8]),
                highc, int'(VEC[i][7:0]));
            chk(rises == 1 && rise_at == 2, "R9 rise position", rise_at, 2);
            chk(scl_fall == 1'b1, "R9 fall at low start", int'(scl_fall), 1);
        end

        // R4: start latency
        enable = 1'b0;
        repeat (3) @(negedge clk);
        rate_sel = 7'd5;
        enable = 1'b1;
        chk(!scl_pull_low, "R4 not yet low", int'(scl_pull_low), 0);
        @(negedge clk);
        chk(scl_pull_low && scl_fall, "R4 low one clock after enable",
            int'({scl_pull_low, scl_fall}), 3);
        @(negedge clk);
        chk(!scl_fall, "R9 fall is one cycle", int'(scl_fall), 0);
        // R4: drop enable in mid low phase
        enable = 1'b0;
        @(negedge clk);
        chk(!scl_pull_low, "R4 disable releases", int'(scl_pull_low), 0);

        // R5: slave stretch of 9 extra edges, rate 5 (half 8)
        restart(7'd5);
        wait_fall();
        lowc = 0;
        while (scl_pull_low && lowc < 2000) begin
            lowc++;
            if (lowc == 8) slave_hold = 1'b1;
            @(negedge clk);
        end
        chk(lowc == 8, "R5 low before stretch", lowc, 8);
        highc = 0; rises = 0; rise_at = 0;
        while (!scl_pull_low && highc < 2000) begin
            highc++;
            if (scl_rise) begin
                rises++;
                if (rise_at == 0) rise_at = highc;
            end
            if (highc == 10) slave_hold = 1'b0;
            @(negedge clk);
        end
        chk(highc == 17, "R5 stretched release time", highc, 17);
        chk(rises == 1 && rise_at == 11, "R5 R9 rise after stretch", rise_at, 11);

        // R6 R7: freeze 20 edges inside a low phase, rate 10 (half 13)
        restart(7'd10);
        dbg_keep_run = 1'b0;
        wait_fall();
        lowc = 0; bad = 0;
        while (scl_pull_low && lowc < 2000) begin
            lowc++;
            if (lowc > 4 && lowc <= 24 && (scl_rise || scl_fall)) bad++;
            if (lowc == 4)  dbg_halt = 1'b1;
            if (lowc == 24) dbg_halt = 1'b0;
            @(negedge clk);
        end
        chk(lowc == 33, "R7 low resumes after freeze", lowc, 33);
        chk(bad == 0, "R6 no strobes while frozen", bad, 0);
        run_high(highc, rises, rise_at);
        chk(highc == 13, "R7 next high normal", highc, 13);

        // R6: freeze inside the high phase keeps the line released
        wait_fall();
        run_low(lowc);
        highc = 0; bad = 0;
        while (!scl_pull_low && highc < 2000) begin
            highc++;
            if (highc == 3)  dbg_halt = 1'b1;
            if (highc > 3 && highc <= 13 && (scl_rise || scl_fall)) bad++;
            if (highc == 13) dbg_halt = 1'b0;
            @(negedge clk);
        end
        chk(highc == 23, "R6 high held during freeze", highc, 23);
        chk(bad == 0, "R6 no strobes in high freeze", bad, 0);

        // R8: keep-run ignores debug state
        restart(7'd10);
        dbg_keep_run = 1'b1;
        wait_fall();
        lowc = 0;
        while (scl_pull_low && lowc < 2000) begin
            lowc++;
            if (lowc == 4) dbg_halt = 1'b1;
            @(negedge clk);
        end
        chk(lowc == 13, "R8 keep-run low length", lowc, 13);
        run_high(highc, rises, rise_at);
        chk(highc == 13, "R8 keep-run high length", highc, 13);
        dbg_halt = 1'b0;
        dbg_keep_run = 1'b0;

        // R3: slave mode stays idle
        enable = 1'b0;
        @(negedge clk);
        master_mode = 1'b0;
        enable = 1'b1;
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (scl_pull_low || scl_rise || scl_fall) bad++;
        end
        chk(bad == 0, "R3 slave mode idle", bad, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule